// File: doc/BRIEF.md
# Phase-Shifted Dithered PWM Engine

This block turns eighteen per-channel brightness codes into eighteen on/off LED drive signals. A shared timebase divides the system clock by a power of two and runs a period counter whose length is set by a resolution select: 8, 9 or 12 bits. A fourth setting keeps the 9-bit period and recovers 12-bit resolution by stretching some periods by one count, following an eight-period pattern driven by the three low code bits.

The channels form six groups of three neighbours. With staggering enabled, each group starts its pulse a sixth of a period after the group before it, so at most one group switches on at a time. Each group can also move its middle channel by half a period to smooth the supply current. A duty-override field drives every output fully on whatever the codes say. Codes, resolution, staggering and inversion settings are captured only when a period ends, so a pulse is never cut short or doubled by a write.

Top module: `pwm_phase_engine`

## Requirements
- R1: While reset is asserted, and afterwards until a nonzero code has been captured, every output is low.
- R2: In 8-bit mode (select 00) the period is 256 ticks and a channel is high for code[7:0] ticks per period; code bits above bit 7 have no effect.
- R3: One tick lasts 2^D clock cycles, where D is the 3-bit divider select.
- R4: In 9-bit mode (select 01) the period is 512 ticks with code[8:0] high ticks; in 12-bit mode (select 10) it is 4096 ticks with code[11:0] high ticks.
- R5: In dither mode (select 11) the period is 512 ticks, and over any eight consecutive periods a channel is high for 8*code[11:3] + code[2:0] ticks.
- R6: In dither mode a period gets one extra high tick when code[2:0] is greater than the bit-reversed 3-bit period index, so the extra ticks are spread: with code[2:0]=4 no two neighbouring periods both carry one, and with code[2:0]=1 exactly one period in eight does.
- R7: A code of zero keeps its channel low for the whole period; a code with all active bits set (all twelve bits in dither mode) keeps it high on every tick with no low gap.
- R8: With staggering on, the pulse of group g (channels 3g to 3g+2, counted from 0) starts floor(g*P/6) ticks after that of group 0, where P is the period in ticks; with it off all groups start together. The duty is unchanged.
- R9: Setting inversion bit g delays only channel 3g+1 by P/2 ticks; channels 3g and 3g+2 keep their timing and the duty is unchanged.
- R10: When the 3-bit override equals 111 every output is high from the next clock on, whatever the codes; any other override value has no effect.
- R11: New codes, resolution, staggering and inversion settings take effect only at the next period boundary; the period in progress completes with the old values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| code_i | input | 216 | Eighteen 12-bit brightness codes, channel k in bits 12k+11:12k |
| res_sel_i | input | 2 | Resolution: 00 8-bit, 01 9-bit, 10 12-bit, 11 9-bit with dither |
| div_sel_i | input | 3 | Tick length exponent: one tick is 2^value clocks |
| phase_en_i | input | 1 | Enables the six-group stagger |
| inv_en_i | input | 6 | Per-group inversion of the middle channel |
| dcpwm_i | input | 3 | Duty override; 111 forces every output high |
| led_o | output | 18 | Channel drive, 1 = LED on |

## Verification
The bench builds the engine with its default parameters: six groups of three channels, 12-bit codes and a 3-bit divider select. With these the 8-bit period at divider 0 is 256 clocks, so staggering offsets of 42, 128 and 213 and the half-period inversion delay of 128 are measured directly as clock counts between rising edges. The full 4096-clock dither pattern and the 12-bit period fit in a short window, and divider settings up to 2 are covered without long runs.

// File: rtl/pwm_eng_pkg.sv
package pwm_eng_pkg;

  // Resolution select encoding; the values are part of the block's interface.
  typedef enum logic [1:0] {
    RES_8  = 2'b00,
    RES_9  = 2'b01,
    RES_12 = 2'b10,
    RES_9D = 2'b11
  } res_e;

  localparam int W_LO   = 8;
  localparam int W_MID  = 9;
  localparam int W_HI   = 12;
  localparam int DITH_W = W_HI - W_MID;

  // Number of counter bits making up one period for a resolution select.
  function automatic logic [3:0] res_bits(res_e r);
    logic [3:0] b;
    case (r)
      RES_8:   b = 4'(W_LO);
      RES_9:   b = 4'(W_MID);
      RES_12:  b = 4'(W_HI);
      default: b = 4'(W_MID);
    endcase
    return b;
  endfunction

  // Bit reversal of the dither frame index, spreading extra ticks evenly.
  function automatic logic [DITH_W-1:0] rev_frame(logic [DITH_W-1:0] v);
    logic [DITH_W-1:0] r;
    for (int i = 0; i < DITH_W; i++) r[i] = v[DITH_W-1-i];
    return r;
  endfunction

endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_eng_pkg::*;
#(
  parameter int DIV_W = 3,
  parameter int CNT_W = 12,
  parameter int FRM_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  input  res_e             res_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [FRM_W-1:0] frame_o,
  output logic             wrap_o,
  output res_e             res_o
);

  localparam int PRE_W = (1 << DIV_W) - 1;

  logic [PRE_W-1:0] pre_q, pre_d, pre_lim;
  logic [PRE_W:0]   pre_span;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_lim;
  logic [CNT_W:0]   per_span;
  logic [FRM_W-1:0] frame_q, frame_d;
  res_e             res_q, res_d;
  logic             tick, wrap;

  // Prescaler limit and period limit
  always_comb begin
    pre_span = (PRE_W+1)'(1) << div_i;
    pre_lim  = PRE_W'(pre_span - 1'b1);
    per_span = (CNT_W+1)'(1) << res_bits(res_q);
    cnt_lim  = CNT_W'(per_span - 1'b1);
  end

  // Next state
  always_comb begin
    tick    = (pre_q >= pre_lim);
    wrap    = tick && (cnt_q >= cnt_lim);
    pre_d   = tick ? '0 : pre_q + 1'b1;
    cnt_d   = cnt_q;
    frame_d = frame_q;
    res_d   = res_q;
    if (tick) begin
      cnt_d = wrap ? '0 : cnt_q + 1'b1;
    end
    if (wrap) begin
      frame_d = frame_q + 1'b1;
      res_d   = res_i;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q   <= '0;
      cnt_q   <= '0;
      frame_q <= '0;
      res_q   <= RES_8;
    end else begin
      pre_q   <= pre_d;
      cnt_q   <= cnt_d;
      frame_q <= frame_d;
      res_q   <= res_d;
    end
  end

  assign cnt_o   = cnt_q;
  assign frame_o = frame_q;
  assign wrap_o  = wrap;
  assign res_o   = res_q;

  // R2
  cnt_in_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= cnt_lim)
    else $error("period counter beyond period");

  // R11
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(res_q))
    else $error("resolution moved inside a period");

  // R6
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(frame_q))
    else $error("dither frame moved inside a period");

endmodule

// File: rtl/pwm_shadow.sv
module pwm_shadow #(
  parameter int NCH     = 18,
  parameter int CODE_W  = 12,
  parameter int NUM_GRP = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wrap_i,
  input  logic [NCH*CODE_W-1:0] code_i,
  input  logic                  phase_i,
  input  logic [NUM_GRP-1:0]    inv_i,
  output logic [NCH*CODE_W-1:0] code_o,
  output logic                  phase_o,
  output logic [NUM_GRP-1:0]    inv_o
);

  logic [NCH*CODE_W-1:0] code_q, code_d;
  logic                  phase_q, phase_d;
  logic [NUM_GRP-1:0]    inv_q, inv_d;

  // Next state: capture only at a period boundary
  always_comb begin
    code_d  = code_q;
    phase_d = phase_q;
    inv_d   = inv_q;
    if (wrap_i) begin
      code_d  = code_i;
      phase_d = phase_i;
      inv_d   = inv_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= '0;
      phase_q <= 1'b0;
      inv_q   <= '0;
    end else begin
      code_q  <= code_d;
      phase_q <= phase_d;
      inv_q   <= inv_d;
    end
  end

  assign code_o  = code_q;
  assign phase_o = phase_q;
  assign inv_o   = inv_q;

  // R11
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_i |=> ($stable(code_q) && $stable(phase_q) && $stable(inv_q)))
    else $error("captured settings changed inside a period");

endmodule

// File: rtl/pwm_duty.sv
module pwm_duty
  import pwm_eng_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int CNT_W  = 12
) (
  input  logic [CODE_W-1:0] code_i,
  input  res_e              res_i,
  input  logic [DITH_W-1:0] frame_i,
  output logic [CNT_W:0]    duty_o,
  output logic              full_o
);

  localparam int BASE_W = CODE_W - DITH_W;

  logic [BASE_W-1:0] base;
  logic [DITH_W-1:0] frac;
  logic              extra;

  always_comb begin
    base  = code_i[CODE_W-1:DITH_W];
    frac  = code_i[DITH_W-1:0];
    extra = (frac > rev_frame(frame_i));
    case (res_i)
      RES_8: begin
        duty_o = (CNT_W+1)'(code_i[W_LO-1:0]);
        full_o = &code_i[W_LO-1:0];
      end
      RES_9: begin
        duty_o = (CNT_W+1)'(code_i[W_MID-1:0]);
        full_o = &code_i[W_MID-1:0];
      end
      RES_12: begin
        duty_o = (CNT_W+1)'(code_i);
        full_o = &code_i;
      end
      default: begin
        duty_o = (CNT_W+1)'(base) + (CNT_W+1)'(extra);
        full_o = &code_i;
      end
    endcase
  end

endmodule

// File: rtl/pwm_slot.sv
module pwm_slot #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] shift_i,
  input  logic [CNT_W-1:0] mask_i,
  input  logic [CNT_W:0]   duty_i,
  input  logic             full_i,
  input  logic             force_i,
  output logic             led_o
);

  logic [CNT_W-1:0] pos;
  logic             on_d, led_q;

  always_comb begin
    pos  = (cnt_i - shift_i) & mask_i;
    on_d = force_i || full_i || ({1'b0, pos} < duty_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) led_q <= 1'b0;
    else        led_q <= on_d;
  end

  assign led_o = led_q;

  // R10
  force_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_i |=> led_q)
    else $error("override did not drive output high");

  // R7
  zero_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_i == '0 && !full_i && !force_i) |=> !led_q)
    else $error("zero duty produced a high output");

  // R7
  full_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full_i |=> led_q)
    else $error("full-scale code produced a low output");

endmodule

// File: rtl/pwm_phase_engine.sv
module pwm_phase_engine
  import pwm_eng_pkg::*;
#(
  parameter int NUM_GRP  = 6,
  parameter int GRP_SIZE = 3,
  parameter int CODE_W   = 12,
  parameter int DIV_W    = 3,
  parameter int FRC_W    = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_GRP*GRP_SIZE*CODE_W-1:0] code_i,
  input  logic [1:0]                     res_sel_i,
  input  logic [DIV_W-1:0]               div_sel_i,
  input  logic                           phase_en_i,
  input  logic [NUM_GRP-1:0]             inv_en_i,
  input  logic [FRC_W-1:0]               dcpwm_i,
  output logic [NUM_GRP*GRP_SIZE-1:0]    led_o
);

  localparam int NCH   = NUM_GRP * GRP_SIZE;
  localparam int CNT_W = CODE_W;
  localparam int MID   = GRP_SIZE / 2;
  localparam int OFF_W = CNT_W + $clog2(NUM_GRP) + 1;

  // Reset: asynchronous assert, synchronous release
  logic [1:0] rst_ff;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff <= '0;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_core_n = rst_ff[1];

  logic [CNT_W-1:0]      cnt;
  logic [DITH_W-1:0]     frame;
  logic                  wrap;
  res_e                  res_q;
  logic [NCH*CODE_W-1:0] code_q;
  logic                  phase_q;
  logic [NUM_GRP-1:0]    inv_q;
  logic [CNT_W:0]        per_span;
  logic [CNT_W-1:0]      mask, half;
  logic                  force_on;

  pwm_timebase #(
    .DIV_W (DIV_W),
    .CNT_W (CNT_W),
    .FRM_W (DITH_W)
  ) u_tb (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .div_i   (div_sel_i),
    .res_i   (res_e'(res_sel_i)),
    .cnt_o   (cnt),
    .frame_o (frame),
    .wrap_o  (wrap),
    .res_o   (res_q)
  );

  pwm_shadow #(
    .NCH     (NCH),
    .CODE_W  (CODE_W),
    .NUM_GRP (NUM_GRP)
  ) u_shadow (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .wrap_i  (wrap),
    .code_i  (code_i),
    .phase_i (phase_en_i),
    .inv_i   (inv_en_i),
    .code_o  (code_q),
    .phase_o (phase_q),
    .inv_o   (inv_q)
  );

  always_comb begin
    per_span = (CNT_W+1)'(1) << res_bits(res_q);
    mask     = CNT_W'(per_span - 1'b1);
    half     = CNT_W'(per_span >> 1);
    force_on = (dcpwm_i == {FRC_W{1'b1}});
  end

  logic [CNT_W-1:0] goff [NUM_GRP];

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic [OFF_W-1:0] scaled;
    assign scaled  = (OFF_W'(g) << res_bits(res_q)) / OFF_W'(NUM_GRP);
    assign goff[g] = phase_q ? CNT_W'(scaled) : '0;

    for (genvar m = 0; m < GRP_SIZE; m++) begin : g_ch
      localparam int CH = g * GRP_SIZE + m;
      logic [CNT_W-1:0] shift;
      logic [CNT_W:0]   duty;
      logic             full;

      if (m == MID) begin : g_mid
        assign shift = (goff[g] + (inv_q[g] ? half : '0)) & mask;
      end else begin : g_side
        assign shift = goff[g];
      end

      pwm_duty #(
        .CODE_W (CODE_W),
        .CNT_W  (CNT_W)
      ) u_duty (
        .code_i  (code_q[CH*CODE_W +: CODE_W]),
        .res_i   (res_q),
        .frame_i (frame),
        .duty_o  (duty),
        .full_o  (full)
      );

      pwm_slot #(
        .CNT_W (CNT_W)
      ) u_slot (
        .clk     (clk),
        .rst_n   (rst_core_n),
        .cnt_i   (cnt),
        .shift_i (shift),
        .mask_i  (mask),
        .duty_i  (duty),
        .full_i  (full),
        .force_i (force_on),
        .led_o   (led_o[CH])
      );
    end
  end

endmodule

// File: tb/tb_pwm_phase_engine.sv
module tb_pwm_phase_engine;
  localparam int NCH = 18;
  localparam int CW  = 12;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NCH*CW-1:0] code;
  logic [1:0]        res_sel;
  logic [2:0]        div_sel;
  logic              phase_en;
  logic [5:0]        inv_en;
  logic [2:0]        dcpwm;
  logic [NCH-1:0]    led;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  pwm_phase_engine dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .code_i     (code),
    .res_sel_i  (res_sel),
    .div_sel_i  (div_sel),
    .phase_en_i (phase_en),
    .inv_en_i   (inv_en),
    .dcpwm_i    (dcpwm),
    .led_o      (led)
  );

  // Stimulus/expectation table: resolution, divider, code, window, high count
  localparam int NV = 14;
  localparam logic [1:0]  V_RES [NV] = '{2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00,
                                         2'b01, 2'b01, 2'b01, 2'b10, 2'b10,
                                         2'b11, 2'b11, 2'b11};
  localparam logic [2:0]  V_DIV [NV] = '{3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd2,
                                         3'd0, 3'd0, 3'd0, 3'd0, 3'd0,
                                         3'd0, 3'd1, 3'd0};
  localparam logic [11:0] V_CODE [NV] = '{12'h000, 12'h080, 12'hF40, 12'h0FF, 12'h0FE, 12'h010,
                                          12'h100, 12'h1FF, 12'hE01, 12'h800, 12'hFFF,
                                          12'h80D, 12'hFFF, 12'h007};
  localparam int V_WIN [NV] = '{256, 256, 256, 256, 256, 1024,
                                512, 512, 512, 4096, 4096,
                                4096, 8192, 4096};
  localparam int V_EXP [NV] = '{0, 128, 64, 256, 254, 64,
                                256, 512, 1, 2048, 4096,
                                2061, 8192, 7};
  localparam string V_REQ [NV] = '{"R7", "R2", "R2", "R7", "R2", "R3",
                                   "R4", "R7", "R4", "R4", "R7",
                                   "R5", "R7", "R5"};

  task automatic chk(input string req, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_all(input logic [11:0] c);
    for (int i = 0; i < NCH; i++) code[i*CW +: CW] = c;
  endtask

  task automatic measure(input int win, output int hc [NCH]);
    for (int i = 0; i < NCH; i++) hc[i] = 0;
    for (int k = 0; k < win; k++) begin
      @(negedge clk);
      for (int i = 0; i < NCH; i++) hc[i] += int'(led[i]);
    end
  endtask

  task automatic align_rise0();
    logic pv;
    @(negedge clk);
    pv = led[0];
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      if (led[0] && !pv) return;
      pv = led[0];
    end
  endtask

  task automatic lag_of(input int tgt, output int lag);
    logic [NCH-1:0] pv, cv;
    @(negedge clk);
    pv = led;
    cv = led;
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      cv = led;
      if (cv[0] && !pv[0]) break;
      pv = cv;
    end
    lag = 0;
    if (cv[tgt] && !pv[tgt]) return;
    pv = cv;
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      cv = led;
      lag++;
      if (cv[tgt] && !pv[tgt]) return;
      pv = cv;
    end
    lag = -1;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    int hc [NCH];
    int lg, tot, nx;
    int pc [8];

    rst_n    = 1'b0;
    set_all(12'h000);
    res_sel  = 2'b00;
    div_sel  = 3'd0;
    phase_en = 1'b0;
    inv_en   = '0;
    dcpwm    = 3'b000;
    repeat (5) @(negedge clk);
    // R1: low during reset
    chk("R1", int'(led), 0, "outputs in reset");
    rst_n = 1'b1;
    measure(300, hc);
    tot = 0;
    for (int i = 0; i < NCH; i++) tot += hc[i];
    // R1: low after release with zero codes
    chk("R1", tot, 0, "high samples after release");

    // Table walk
    for (int v = 0; v < NV; v++) begin
      res_sel = V_RES[v];
      div_sel = V_DIV[v];
      set_all(V_CODE[v]);
      repeat (4200 + V_WIN[v]) @(negedge clk);
      measure(V_WIN[v], hc);
      for (int i = 0; i < NCH; i += 5)
        chk(V_REQ[v], hc[i], V_EXP[v], $sformatf("vector %0d ch %0d high count", v, i));
    end

    // R10: override forces all high, other values do nothing
    res_sel = 2'b00;
    div_sel = 3'd0;
    set_all(12'h080);
    repeat (4500) @(negedge clk);
    dcpwm = 3'b111;
    @(negedge clk);
    chk("R10", int'(led), int'({NCH{1'b1}}), "outputs one clock after override");
    measure(256, hc);
    chk("R10", hc[9], 256, "ch 9 high count under override");
    dcpwm = 3'b110;
    @(negedge clk);
    measure(256, hc);
    chk("R10", hc[9], 128, "ch 9 high count with override 110");
    dcpwm = 3'b000;

    // R8: group stagger
    phase_en = 1'b1;
    repeat (600) @(negedge clk);
    lag_of(3, lg);  chk("R8", lg, 42,  "group 1 start lag");
    lag_of(4, lg);  chk("R8", lg, 42,  "group 1 middle start lag");
    lag_of(9, lg);  chk("R8", lg, 128, "group 3 start lag");
    lag_of(15, lg); chk("R8", lg, 213, "group 5 start lag");
    measure(256, hc);
    chk("R8", hc[15], 128, "group 5 duty under stagger");
    phase_en = 1'b0;
    repeat (600) @(negedge clk);
    lag_of(15, lg); chk("R8", lg, 0, "group 5 lag with stagger off");

    // R9: middle-channel inversion
    inv_en = 6'b000101;
    repeat (600) @(negedge clk);
    lag_of(1, lg); chk("R9", lg, 128, "group 0 middle lag");
    lag_of(2, lg); chk("R9", lg, 0,   "group 0 last channel lag");
    lag_of(7, lg); chk("R9", lg, 128, "group 2 middle lag");
    lag_of(4, lg); chk("R9", lg, 0,   "group 1 middle lag, bit clear");
    measure(256, hc);
    chk("R9", hc[1], 128, "inverted channel duty");
    inv_en = '0;
    repeat (600) @(negedge clk);

    // R11: a mid-period write waits for the boundary
    align_rise0();
    repeat (10) @(negedge clk);
    set_all(12'h010);
    measure(245, hc);
    chk("R11", hc[0], 117, "rest of period after mid-period write");
    measure(256, hc);
    chk("R11", hc[0], 16, "next period with new code");

    // R6: spread of dither extras
    res_sel = 2'b11;
    set_all(12'h804);
    repeat (5000) @(negedge clk);
    align_rise0();
    for (int p = 0; p < 8; p++) begin
      pc[p] = (p == 0) ? 1 : 0;
      for (int k = (p == 0) ? 1 : 0; k < 512; k++) begin
        @(negedge clk);
        pc[p] += int'(led[0]);
      end
    end
    tot = 0;
    nx  = 0;
    for (int p = 0; p < 8; p++) begin
      tot += pc[p];
      if (pc[p] == 257 && pc[(p + 1) % 8] == 257) nx++;
    end
    chk("R6", tot, 2052, "eight-period total, frac 4");
    chk("R6", nx, 0, "neighbouring periods both extended, frac 4");
    set_all(12'h801);
    repeat (5000) @(negedge clk);
    align_rise0();
    for (int p = 0; p < 8; p++) begin
      pc[p] = (p == 0) ? 1 : 0;
      for (int k = (p == 0) ? 1 : 0; k < 512; k++) begin
        @(negedge clk);
        pc[p] += int'(led[0]);
      end
    end
    nx = 0;
    for (int p = 0; p < 8; p++) if (pc[p] == 257) nx++;
    chk("R6", nx, 1, "extended periods, frac 1");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule